// File: doc/BRIEF.md
# Calendar Clock with Second Trim

This block keeps wall-clock time and calendar date from a one-cycle-per-second enable pulse. It holds seconds, minutes, hours, day of week, day of month, month and a two-digit year. Time advances by one second on each enable pulse, and carries run through every field, including month lengths and leap years.

Software reaches the block through a write-only register port. Every write that changes state (a field value or a trim request) must come right after an unlock write. A trim request adds or removes a single second at the next enable pulse. After a trim has been applied, the block ignores new requests until two more seconds have passed.

Top module: `cal_clock`

## Requirements
- R1: After a synchronous reset, the time reads 00:00:00, weekday 1, date 1, month 1 and year 0. No unlock is armed and no trim is pending.
- R2: An enable pulse on `tick_1s` with no trim pending advances the time by one second. Seconds carry into minutes at 59, and minutes carry into hours at 59. Hours wrap from 23 to 0 and carry into the day fields. With no enable pulse and no write, every field holds its value.
- R3: A day carry moves the weekday from 7 to 1 and otherwise up by one. It moves the date to 1 once the date has reached the month length and otherwise up by one. Month lengths are 30 days for months 4, 6, 9 and 11, and 31 days for all other months except February. February has 29 days when the year is a multiple of 4 (0 counts) and 28 days otherwise. Month carries from 12 to 1, and year wraps from 99 to 0.
- R4: The register map is: addresses 0 to 6 hold second, minute, hour, weekday, date, month and year; address 7 takes trim requests; address 15 is the unlock. A write to address 15 arms the unlock, whatever its data. A write to addresses 0 to 6 changes its field only when the unlock is armed; otherwise it is ignored.
- R5: Any write to an address other than 15 disarms the unlock, whether or not that write is accepted. This includes writes to unused addresses 8 to 14.
- R6: A field write is ignored when its value is out of range. The ranges are: second and minute 0 to 59, hour 0 to 23, weekday 1 to 7, date 1 to 31, month 1 to 12, year 0 to 99.
- R7: A write to address 7 while armed is a trim request. Data bits [1:0] = 01 request an advance; at the next enable pulse the time moves by two seconds, with normal carries. Data bits [1:0] = 10 request a retard; at the next enable pulse the time is unchanged. Values 00 and 11 are ignored, and higher data bits have no effect.
- R8: At most one trim is pending at a time. A request made while a trim is pending is ignored.
- R9: Once a trim is applied, new trim requests are ignored until two more enable pulses have occurred.
- R10: When an accepted field write and an enable pulse fall in the same cycle, the written field takes the written value and the other fields follow the one-second advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | One-second enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register write address |
| wr_data | input | 8 | Register write data |
| sec_o | output | 6 | Seconds, 0 to 59 |
| min_o | output | 6 | Minutes, 0 to 59 |
| hr_o | output | 5 | Hours, 0 to 23 |
| wday_o | output | 3 | Day of week, 1 to 7 |
| date_o | output | 5 | Day of month, 1 to 31 |
| mon_o | output | 4 | Month, 1 to 12 |
| yr_o | output | 7 | Year, 0 to 99 |

## Verification
All state is visible on the field outputs one cycle after the enable pulse or write that changes it, so a wrong carry or a wrong month length appears on the very next second. A wrong unlock or trim state does not show at once. It appears as an accepted or refused field write in the following cycle, or as a step of 0, 1 or 2 seconds at the next enable pulse. For that reason the bench checks all seven fields after every single operation. Directed runs cover year-end rollover, February in leap and common years, trims that carry across minute boundaries, and trims issued inside the two-second guard window.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int DATA_W    = 8;
  localparam int N_FIELDS  = 7;

  localparam logic [2:0] F_SEC  = 3'd0;
  localparam logic [2:0] F_MIN  = 3'd1;
  localparam logic [2:0] F_HR   = 3'd2;
  localparam logic [2:0] F_WDAY = 3'd3;
  localparam logic [2:0] F_DATE = 3'd4;
  localparam logic [2:0] F_MON  = 3'd5;
  localparam logic [2:0] F_YR   = 3'd6;

  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mon;
    logic [4:0] date;
    logic [2:0] wday;
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_t;

  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] yr);
    case (mon)
      4'd2:                      month_len = (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   month_len = 5'd30;
      default:                   month_len = 5'd31;
    endcase
  endfunction

  function automatic logic value_ok(input logic [2:0] idx, input logic [DATA_W-1:0] v);
    case (idx)
      F_SEC, F_MIN: value_ok = (v < 8'd60);
      F_HR:         value_ok = (v < 8'd24);
      F_WDAY:       value_ok = (v >= 8'd1) && (v <= 8'd7);
      F_DATE:       value_ok = (v >= 8'd1) && (v <= 8'd31);
      F_MON:        value_ok = (v >= 8'd1) && (v <= 8'd12);
      F_YR:         value_ok = (v < 8'd100);
      default:      value_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cal_access.sv
module cal_access
  import cal_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int UNLOCK_ADDR = 15,
  parameter int TRIM_ADDR   = 7,
  parameter int GUARD_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fld_we,
  output logic [2:0]        fld_idx,
  output logic [DATA_W-1:0] fld_val,
  output logic [1:0]        step,
  output logic              armed,
  output logic              adv_pend,
  output logic              ret_pend
);

  localparam int GW = $clog2(GUARD_TICKS + 1);

  logic          armed_q, adv_q, ret_q;
  logic [GW-1:0] guard_q;
  logic          is_unlock, is_other, granted, trim_ok;

  always_comb begin
    is_unlock = wr_en && (wr_addr == ADDR_W'(UNLOCK_ADDR));
    is_other  = wr_en && !is_unlock;
    granted   = is_other && armed_q;
    fld_idx   = wr_addr[2:0];
    fld_val   = wr_data;
    fld_we    = granted && (wr_addr < ADDR_W'(N_FIELDS)) && value_ok(wr_addr[2:0], wr_data);
    trim_ok   = granted && (wr_addr == ADDR_W'(TRIM_ADDR)) && !adv_q && !ret_q &&
                (guard_q == '0) && (wr_data[1] ^ wr_data[0]);
    if (!tick)      step = 2'd0;
    else if (adv_q) step = 2'd2;
    else if (ret_q) step = 2'd0;
    else            step = 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      adv_q   <= 1'b0;
      ret_q   <= 1'b0;
      guard_q <= '0;
    end else begin
      if (is_unlock)     armed_q <= 1'b1;
      else if (is_other) armed_q <= 1'b0;

      if (tick) begin
        adv_q <= 1'b0;
        ret_q <= 1'b0;
        if (adv_q || ret_q)      guard_q <= GW'(GUARD_TICKS);
        else if (guard_q != '0)  guard_q <= guard_q - 1'b1;
      end
      if (trim_ok) begin
        adv_q <= wr_data[0];
        ret_q <= wr_data[1];
      end
    end
  end

  assign armed    = armed_q;
  assign adv_pend = adv_q;
  assign ret_pend = ret_q;

endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        step,
  input  logic              fld_we,
  input  logic [2:0]        fld_idx,
  input  logic [DATA_W-1:0] fld_val,
  output cal_t              now
);

  cal_t       cur_q, nx;
  logic [6:0] sec_sum;
  logic       c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    nx      = cur_q;
    c_min   = 1'b0;
    c_hr    = 1'b0;
    c_day   = 1'b0;
    c_mon   = 1'b0;
    c_yr    = 1'b0;
    sec_sum = {1'b0, cur_q.sec} + {5'b0, step};

    if (sec_sum >= 7'd60) begin
      nx.sec = 6'(sec_sum - 7'd60);
      c_min  = 1'b1;
    end else begin
      nx.sec = sec_sum[5:0];
    end

    if (c_min) begin
      if (cur_q.min >= 6'd59) begin nx.min = 6'd0; c_hr = 1'b1; end
      else nx.min = cur_q.min + 6'd1;
    end

    if (c_hr) begin
      if (cur_q.hr >= 5'd23) begin nx.hr = 5'd0; c_day = 1'b1; end
      else nx.hr = cur_q.hr + 5'd1;
    end

    if (c_day) begin
      nx.wday = (cur_q.wday >= 3'd7) ? 3'd1 : cur_q.wday + 3'd1;
      if (cur_q.date >= month_len(cur_q.mon, cur_q.yr)) begin
        nx.date = 5'd1;
        c_mon   = 1'b1;
      end else begin
        nx.date = cur_q.date + 5'd1;
      end
    end

    if (c_mon) begin
      if (cur_q.mon >= 4'd12) begin nx.mon = 4'd1; c_yr = 1'b1; end
      else nx.mon = cur_q.mon + 4'd1;
    end

    if (c_yr) nx.yr = (cur_q.yr >= 7'd99) ? 7'd0 : cur_q.yr + 7'd1;

    if (fld_we) begin
      case (fld_idx)
        F_SEC:   nx.sec  = fld_val[5:0];
        F_MIN:   nx.min  = fld_val[5:0];
        F_HR:    nx.hr   = fld_val[4:0];
        F_WDAY:  nx.wday = fld_val[2:0];
        F_DATE:  nx.date = fld_val[4:0];
        F_MON:   nx.mon  = fld_val[3:0];
        F_YR:    nx.yr   = fld_val[6:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '{yr: 7'd0, mon: 4'd1, date: 5'd1, wday: 3'd1, hr: 5'd0, min: 6'd0, sec: 6'd0};
    end else begin
      cur_q <= nx;
    end
  end

  assign now = cur_q;

endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int UNLOCK_ADDR = 15,
  parameter int TRIM_ADDR   = 7,
  parameter int GUARD_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1s,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [5:0]        sec_o,
  output logic [5:0]        min_o,
  output logic [4:0]        hr_o,
  output logic [2:0]        wday_o,
  output logic [4:0]        date_o,
  output logic [3:0]        mon_o,
  output logic [6:0]        yr_o
);

  logic              fld_we;
  logic [2:0]        fld_idx;
  logic [DATA_W-1:0] fld_val;
  logic [1:0]        step;
  logic              armed, adv_pend, ret_pend;
  cal_t              now;

  cal_access #(
    .ADDR_W      (ADDR_W),
    .UNLOCK_ADDR (UNLOCK_ADDR),
    .TRIM_ADDR   (TRIM_ADDR),
    .GUARD_TICKS (GUARD_TICKS)
  ) u_access (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_1s),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .fld_we   (fld_we),
    .fld_idx  (fld_idx),
    .fld_val  (fld_val),
    .step     (step),
    .armed    (armed),
    .adv_pend (adv_pend),
    .ret_pend (ret_pend)
  );

  cal_counter u_counter (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .fld_we  (fld_we),
    .fld_idx (fld_idx),
    .fld_val (fld_val),
    .now     (now)
  );

  assign sec_o  = now.sec;
  assign min_o  = now.min;
  assign hr_o   = now.hr;
  assign wday_o = now.wday;
  assign date_o = now.date;
  assign mon_o  = now.mon;
  assign yr_o   = now.yr;

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk #(
  parameter int ADDR_W      = 4,
  parameter int UNLOCK_ADDR = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_1s,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [5:0]        sec_o,
  input logic [5:0]        min_o,
  input logic [4:0]        hr_o,
  input logic [2:0]        wday_o,
  input logic [4:0]        date_o,
  input logic [3:0]        mon_o,
  input logic [6:0]        yr_o,
  input logic              armed,
  input logic              adv_pend,
  input logic              ret_pend
);

  logic [35:0] all_f;
  assign all_f = {yr_o, mon_o, date_o, wday_o, hr_o, min_o, sec_o};

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!tick_1s && !wr_en) |=> $stable(all_f));

  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    (tick_1s && !wr_en && !adv_pend && !ret_pend && sec_o < 6'd59) |=> (sec_o == $past(sec_o) + 6'd1));

  a_r4_locked_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !armed && wr_addr != ADDR_W'(UNLOCK_ADDR) && !tick_1s) |=> $stable(all_f));

  a_r6_fields_in_range: assert property (@(posedge clk) disable iff (rst)
    (sec_o < 6'd60 && min_o < 6'd60 && hr_o < 5'd24 && wday_o >= 3'd1 &&
     date_o >= 5'd1 && mon_o >= 4'd1 && mon_o <= 4'd12 && yr_o < 7'd100));

  a_r7_advance_two: assert property (@(posedge clk) disable iff (rst)
    (tick_1s && !wr_en && adv_pend && sec_o < 6'd58) |=> (sec_o == $past(sec_o) + 6'd2));

  a_r7_retard_holds: assert property (@(posedge clk) disable iff (rst)
    (tick_1s && !wr_en && ret_pend) |=> $stable(all_f));

  a_r8_single_pending: assert property (@(posedge clk) disable iff (rst)
    $onehot0({adv_pend, ret_pend}));

endmodule

bind cal_clock cal_clock_chk #(
  .ADDR_W      (ADDR_W),
  .UNLOCK_ADDR (UNLOCK_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_1s  (tick_1s),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .sec_o    (sec_o),
  .min_o    (min_o),
  .hr_o     (hr_o),
  .wday_o   (wday_o),
  .date_o   (date_o),
  .mon_o    (mon_o),
  .yr_o     (yr_o),
  .armed    (armed),
  .adv_pend (adv_pend),
  .ret_pend (ret_pend)
);

// File: tb/cal_clock_test.sv
module cal_clock_test;

  localparam int CLK_PERIOD = 10;
  localparam int UNL = 15;
  localparam int TRM = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1s = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [5:0] sec_o, min_o;
  logic [4:0] hr_o, date_o;
  logic [2:0] wday_o;
  logic [3:0] mon_o;
  logic [6:0] yr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  int e_f[7];
  bit e_armed;
  bit e_adv, e_ret;
  int e_guard;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_clock uut (
    .clk(clk), .rst(rst), .tick_1s(tick_1s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .wday_o(wday_o),
    .date_o(date_o), .mon_o(mon_o), .yr_o(yr_o)
  );

  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic bit in_range(int idx, int v);
    case (idx)
      0, 1: return v <= 59;
      2:    return v <= 23;
      3:    return v >= 1 && v <= 7;
      4:    return v >= 1 && v <= 31;
      5:    return v >= 1 && v <= 12;
      6:    return v <= 99;
      default: return 0;
    endcase
  endfunction

  function automatic void m_one_second();
    e_f[0]++;
    if (e_f[0] < 60) return;
    e_f[0] = 0; e_f[1]++;
    if (e_f[1] < 60) return;
    e_f[1] = 0; e_f[2]++;
    if (e_f[2] < 24) return;
    e_f[2] = 0;
    e_f[3] = (e_f[3] == 7) ? 1 : e_f[3] + 1;
    if (e_f[4] < mdays(e_f[5], e_f[6])) begin e_f[4]++; return; end
    e_f[4] = 1; e_f[5]++;
    if (e_f[5] <= 12) return;
    e_f[5] = 1;
    e_f[6] = (e_f[6] == 99) ? 0 : e_f[6] + 1;
  endfunction

  function automatic void m_tick();
    int n;
    n = e_adv ? 2 : (e_ret ? 0 : 1);
    if (e_adv || e_ret) e_guard = 2;
    else if (e_guard > 0) e_guard--;
    e_adv = 0; e_ret = 0;
    for (int i = 0; i < n; i++) m_one_second();
  endfunction

  function automatic void m_write(int a, int d);
    if (a == UNL) begin e_armed = 1; return; end
    if (e_armed) begin
      if (a < 7 && in_range(a, d)) e_f[a] = d;
      if (a == TRM && !e_adv && !e_ret && e_guard == 0) begin
        if ((d & 3) == 1) e_adv = 1;
        if ((d & 3) == 2) e_ret = 1;
      end
    end
    e_armed = 0;
  endfunction

  task automatic compare(string req);
    logic [35:0] act, exp;
    act = {yr_o, mon_o, date_o, wday_o, hr_o, min_o, sec_o};
    exp = {7'(e_f[6]), 4'(e_f[5]), 5'(e_f[4]), 3'(e_f[3]), 5'(e_f[2]), 6'(e_f[1]), 6'(e_f[0])};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (yr mon date wday hr min sec)", req, act, exp);
    end
  endtask

  task automatic op_tick(string req);
    @(negedge clk); tick_1s = 1'b1;
    @(negedge clk); tick_1s = 1'b0;
    m_tick();
    compare(req);
  endtask

  task automatic op_write(int a, int d, string req);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 1'b0;
    m_write(a, d);
    compare(req);
  endtask

  // R10: field write and tick in the same cycle
  task automatic op_both(int a, int d, string req);
    @(negedge clk); tick_1s = 1'b1; wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk); tick_1s = 1'b0; wr_en = 1'b0;
    m_tick();
    if (e_armed && in_range(a, d)) e_f[a] = d;
    e_armed = 0;
    compare(req);
  endtask

  task automatic set_time(int y, int mo, int dt, int wd, int h, int mi, int s);
    int v[7];
    v[0] = s; v[1] = mi; v[2] = h; v[3] = wd; v[4] = dt; v[5] = mo; v[6] = y;
    for (int i = 0; i < 7; i++) begin
      op_write(UNL, 0, "R4");
      op_write(i, v[i], "R4");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    e_f[0] = 0; e_f[1] = 0; e_f[2] = 0; e_f[3] = 1; e_f[4] = 1; e_f[5] = 1; e_f[6] = 0;
    e_armed = 0; e_adv = 0; e_ret = 0; e_guard = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R1 reset");

    // R4: locked write ignored, R5: unlock consumed
    op_write(0, 30, "R4 locked write");
    op_write(UNL, 0, "R4 unlock");
    op_write(12, 5, "R5 unused addr consumes");
    op_write(1, 10, "R5 disarmed write");
    op_write(UNL, 0, "R4");
    op_write(1, 10, "R4 armed write");
    op_write(1, 11, "R5 second write refused");
    // R6: out-of-range writes
    op_write(UNL, 0, "R6"); op_write(2, 24, "R6 hour 24");
    op_write(UNL, 0, "R6"); op_write(5, 0, "R6 month 0");
    op_write(UNL, 0, "R6"); op_write(3, 8, "R6 weekday 8");

    // R3: year end
    set_time(99, 12, 31, 7, 23, 59, 59);
    op_tick("R3 year wrap");
    // R3: leap February
    set_time(4, 2, 28, 3, 23, 59, 59);
    op_tick("R3 leap feb 29");
    op_tick("R2 step");
    set_time(4, 2, 29, 3, 23, 59, 59);
    op_tick("R3 leap feb to march");
    set_time(1, 2, 28, 3, 23, 59, 59);
    op_tick("R3 common feb to march");
    set_time(0, 2, 28, 3, 23, 59, 59);
    op_tick("R3 year 0 leap");
    set_time(5, 4, 30, 2, 23, 59, 59);
    op_tick("R3 30-day month");

    // R7: advance across minute boundary, guard R9
    set_time(7, 6, 30, 5, 23, 59, 58);
    op_write(UNL, 0, "R7"); op_write(TRM, 1, "R7 advance request");
    op_write(UNL, 0, "R8"); op_write(TRM, 2, "R8 second request ignored");
    op_tick("R7 advance carries");
    op_write(UNL, 0, "R9"); op_write(TRM, 2, "R9 inside guard");
    op_tick("R9 guarded tick");
    op_tick("R9 guard end");
    op_write(UNL, 0, "R7"); op_write(TRM, 8'hFE, "R7 retard high bits");
    op_tick("R7 retard holds");
    op_tick("R9 guard");
    op_tick("R9 guard");
    op_write(UNL, 0, "R7"); op_write(TRM, 3, "R7 code 11 ignored");
    op_tick("R7 no trim");
    op_write(TRM, 1, "R4 trim without unlock");
    op_tick("R4 trim without unlock no effect");

    // R10
    op_write(UNL, 0, "R10");
    op_both(2, 5, "R10 write with tick");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 40) op_tick("R2 random tick");
      else if (r < 65) op_write(UNL, int'($urandom_range(0, 255)), "R4 random unlock");
      else if (r < 85) op_write(int'($urandom_range(0, 6)), int'($urandom_range(0, 70)), "R6 random field");
      else if (r < 95) op_write(TRM, int'($urandom_range(0, 255)), "R7 random trim");
      else op_write(int'($urandom_range(8, 14)), 0, "R5 random unused");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule